// File: doc/BRIEF.md
# Biphase Stream Lock Monitor

This block watches one serial biphase audio line, oversampled by a fast system clock, and reports whether the receive path may be treated as synchronised. First the line passes through a synchroniser and a short-pulse filter. Then the high and low times of the cleaned line are timed, and the shortest and longest pulse seen during a fixed measurement window are kept. At the end of each window the block sorts the input into one of four classes: nothing there, timing too fine for the system clock, a shape that cannot be biphase audio, or a usable stream.

Once the stream is usable, the block waits for the downstream decoder to report a preamble. When one arrives, the block leaves the unlocked state and raises a sticky lock event. While locked, it watches the decoded bits for a long run of one value and counts preamble errors in a row. Either one sends it back to measuring and sets its own sticky event. The shortest pulse from the last usable window is given out as the unit pulse width, for use by the clock recovery logic.

Top module: `biphase_lock_monitor`

## Requirements
- R1: Enabling raises `unlocked_o` on the clock edge that samples `enable_i` high. While `enable_i` is low, every status output and every sticky flag reads 0.
- R2: A level on `line_i` that lasts one clock cycle or less never reaches the pulse timer. A line that toggles every cycle therefore reads as no signal.
- R3: A measurement window of `WIN_LEN` cycles that times no complete pulse sets `no_signal_o`. The same status is set by a loss of lock (R9).
- R4: With shortest width S and longest width L, the input is reported on `bad_format_o` when 2·L ≤ 5·S or L > 4·S. For example, S=4 with L=10 or L=17 is bad, and S=4 with L=11, 12 or 16 is good.
- R5: When S is below `MIN_RES` (3 cycles), `low_freq_o` is set instead of `bad_format_o`, even if the ratio is also outside the window.
- R6: A window that passes R3 to R5 clears all cause statuses, publishes S on `unit_width_o`, and starts waiting for a preamble.
- R7: While waiting, a `pre_found_i` pulse without `pre_err_i` clears `unlocked_o` and sets the sticky `lock_flag_o` on the next edge. `irq_o` equals `lock_flag_o` AND `lock_irq_en_i`.
- R8: If no preamble comes within `LOCK_TMO` cycles (1.5 frames), measuring starts again, and `pre_found_i` is ignored until the next usable window.
- R9: While locked, `LOSS_RUN` (32) valid decoded bits of one value in a row set the sticky `loss_flag_o`, raise `unlocked_o` and `no_signal_o`, and restart measuring. 31 in a row do not.
- R10: `PERR_MAX` (16) `pre_err_i` pulses in a row set the sticky `rate_chg_flag_o` and restart measuring. A `pre_found_i` without an error resets the count.
- R11: After each restart, S is measured again over a fresh window, so `unit_width_o` follows a changed stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Receiver enable; low clears the block |
| line_i | input | 1 | Raw serial line, asynchronous |
| dec_bit_vld_i | input | 1 | Decoder presents a decoded bit this cycle |
| dec_bit_i | input | 1 | Decoded bit value |
| pre_found_i | input | 1 | Decoder matched a preamble |
| pre_err_i | input | 1 | Decoder saw a preamble error |
| lock_irq_en_i | input | 1 | Lets the lock event drive the interrupt |
| unlocked_o | output | 1 | Enabled and not yet locked |
| no_signal_o | output | 1 | Unlock cause: no pulses / lost stream |
| bad_format_o | output | 1 | Unlock cause: pulse ratio outside window |
| low_freq_o | output | 1 | Unlock cause: clock too slow for the stream |
| lock_flag_o | output | 1 | Sticky lock event |
| loss_flag_o | output | 1 | Sticky loss-of-signal event |
| rate_chg_flag_o | output | 1 | Sticky sample-rate-change event |
| irq_o | output | 1 | Lock interrupt request |
| unit_width_o | output | CW | Shortest pulse width from the last usable window, in clocks |

## Verification
A cause status is due one window after measuring starts: `WIN_LEN` cycles plus a few cycles of synchroniser and filter delay. The bench therefore samples each classification about 1200 cycles after enabling, well inside the wait phase and before the `LOCK_TMO` timeout could change anything. Events driven by the decoder (lock, loss, preamble-error restart) take effect on the edge that samples the last pulse, so those checks read the outputs at the falling edge straight after it. The timeout check waits past `WIN_LEN + LOCK_TMO` and stays well short of the next window end, so a late preamble falls into the measuring phase.

// File: rtl/blm_pkg.sv
`timescale 1ns/1ps
package blm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_SYNC = 2'd2,
        ST_LOCK = 2'd3
    } blm_state_e;

    typedef enum logic [1:0] {
        CZ_NONE  = 2'd0,
        CZ_NOSIG = 2'd1,
        CZ_BADF  = 2'd2,
        CZ_LOWF  = 2'd3
    } blm_cause_e;
endpackage

// File: rtl/blm_deglitch.sv
`timescale 1ns/1ps
module blm_deglitch #(
    parameter int STAGES = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic lvl_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              lvl;
    } dg_t;

    dg_t dg_d, dg_q;

    always_comb begin
        dg_d    = dg_q;
        dg_d.sh = {dg_q.sh[STAGES-2:0], line_i};
        // accept a new level only once it has been seen on two samples in a row
        if ((dg_q.sh[STAGES-1] == dg_q.sh[STAGES-2]) && (dg_q.sh[STAGES-2] != dg_q.lvl))
            dg_d.lvl = dg_q.sh[STAGES-2];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dg_q <= '0;
        else         dg_q <= dg_d;
    end

    assign lvl_o = dg_q.lvl;

    // R2: a filtered level is never shorter than two cycles
    assert_min_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dg_q.lvl != $past(dg_q.lvl)) |=> $stable(dg_q.lvl));
endmodule

// File: rtl/blm_pulse_meter.sv
`timescale 1ns/1ps
module blm_pulse_meter #(
    parameter int CW      = 8,
    parameter int WIN_LEN = 1024
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          lvl_i,
    output logic          done_o,
    output logic          got_o,
    output logic [CW-1:0] min_o,
    output logic [CW-1:0] max_o
);
    localparam int            WW       = $clog2(WIN_LEN);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
    localparam logic [CW-1:0] W_SAT    = '1;

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] len;
        logic          skip;
        logic [WW-1:0] win;
        logic [CW-1:0] mn;
        logic [CW-1:0] mx;
        logic          got;
        logic          done;
        logic [CW-1:0] rmn;
        logic [CW-1:0] rmx;
        logic          rgot;
    } meter_t;

    meter_t m_d, m_q;
    logic   edge_w;

    always_comb begin
        m_d      = m_q;
        m_d.done = 1'b0;
        m_d.prev = lvl_i;
        edge_w   = lvl_i ^ m_q.prev;
        if (!run_i) begin
            m_d.len  = '0;
            m_d.skip = 1'b1;
            m_d.win  = '0;
            m_d.mn   = W_SAT;
            m_d.mx   = '0;
            m_d.got  = 1'b0;
        end else begin
            if (edge_w)                 m_d.len = CW'(1);
            else if (m_q.len != W_SAT)  m_d.len = m_q.len + 1'b1;
            if (edge_w) begin
                // the first level after a start is partial and not timed
                if (m_q.skip) begin
                    m_d.skip = 1'b0;
                end else begin
                    m_d.got = 1'b1;
                    if (m_q.len < m_q.mn) m_d.mn = m_q.len;
                    if (m_q.len > m_q.mx) m_d.mx = m_q.len;
                end
            end
            if (m_q.win == WIN_LAST) begin
                m_d.done = 1'b1;
                m_d.rmn  = m_d.mn;
                m_d.rmx  = m_d.mx;
                m_d.rgot = m_d.got;
                m_d.win  = '0;
                m_d.mn   = W_SAT;
                m_d.mx   = '0;
                m_d.got  = 1'b0;
            end else begin
                m_d.win = m_q.win + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) m_q <= '0;
        else         m_q <= m_d;
    end

    assign done_o = m_q.done;
    assign got_o  = m_q.rgot;
    assign min_o  = m_q.rmn;
    assign max_o  = m_q.rmx;

    // R6: a published window that timed pulses has min not above max
    assert_min_le_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_q.done && m_q.rgot) |-> (m_q.rmn <= m_q.rmx));
    // R11: results appear only while measuring
    assert_done_in_run_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_q.done |-> $past(run_i));
endmodule

// File: rtl/blm_bit_watch.sv
`timescale 1ns/1ps
module blm_bit_watch #(
    parameter int LOSS_RUN = 32,
    parameter int PERR_MAX = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_loss_i,
    input  logic arm_perr_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic pre_found_i,
    input  logic pre_err_i,
    output logic loss_o,
    output logic perr_o
);
    localparam int            RW      = $clog2(LOSS_RUN + 1);
    localparam int            PW      = $clog2(PERR_MAX + 1);
    localparam logic [RW-1:0] RUN_TOP = RW'(LOSS_RUN);
    localparam logic [PW-1:0] PE_TOP  = PW'(PERR_MAX);

    typedef struct packed {
        logic          last;
        logic [RW-1:0] run;
        logic [PW-1:0] pe;
    } watch_t;

    watch_t w_d, w_q;
    logic [RW-1:0] run_nx;
    logic [PW-1:0] pe_nx;

    always_comb begin
        w_d    = w_q;
        loss_o = 1'b0;
        perr_o = 1'b0;
        if ((w_q.run != '0) && (bit_i == w_q.last))
            run_nx = (w_q.run == RUN_TOP) ? RUN_TOP : w_q.run + 1'b1;
        else
            run_nx = RW'(1);
        pe_nx = (w_q.pe == PE_TOP) ? PE_TOP : w_q.pe + 1'b1;

        if (!arm_loss_i) begin
            w_d.run = '0;
        end else if (bit_vld_i) begin
            w_d.run  = run_nx;
            w_d.last = bit_i;
            loss_o   = (run_nx == RUN_TOP);
        end

        if (!arm_perr_i) begin
            w_d.pe = '0;
        end else if (pre_err_i) begin
            w_d.pe = pe_nx;
            perr_o = (pe_nx == PE_TOP);
        end else if (pre_found_i) begin
            w_d.pe = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) w_q <= '0;
        else         w_q <= w_d;
    end

    // R9: run length never goes past the loss limit
    assert_run_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_q.run <= RUN_TOP);
    // R10: a good preamble empties the error count
    assert_perr_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_perr_i && pre_found_i && !pre_err_i) |=> (w_q.pe == '0));
endmodule

// File: rtl/biphase_lock_monitor.sv
`timescale 1ns/1ps
module biphase_lock_monitor
    import blm_pkg::*;
#(
    parameter int CW          = 8,
    parameter int WIN_LEN     = 1024,
    parameter int MIN_RES     = 3,
    parameter int LOCK_TMO    = 768,
    parameter int LOSS_RUN    = 32,
    parameter int PERR_MAX    = 16,
    parameter int SYNC_STAGES = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          enable_i,
    input  logic          line_i,
    input  logic          dec_bit_vld_i,
    input  logic          dec_bit_i,
    input  logic          pre_found_i,
    input  logic          pre_err_i,
    input  logic          lock_irq_en_i,
    output logic          unlocked_o,
    output logic          no_signal_o,
    output logic          bad_format_o,
    output logic          low_freq_o,
    output logic          lock_flag_o,
    output logic          loss_flag_o,
    output logic          rate_chg_flag_o,
    output logic          irq_o,
    output logic [CW-1:0] unit_width_o
);
    localparam int            TW       = $clog2(LOCK_TMO);
    localparam int            XW       = CW + 3;
    localparam logic [TW-1:0] TMO_LAST = TW'(LOCK_TMO - 1);
    localparam logic [CW-1:0] RES_MIN  = CW'(MIN_RES);

    typedef struct packed {
        blm_state_e    st;
        blm_cause_e    cz;
        logic [CW-1:0] unit;
        logic          lk;
        logic          ls;
        logic          rc;
        logic [TW-1:0] tmo;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          lvl_w, done_w, got_w, loss_w, perr_w;
    logic [CW-1:0] mn_w, mx_w;
    logic [XW-1:0] ext_mn, ext_mx, two_mx, five_mn, four_mn;
    logic          ratio_bad, too_fine;

    blm_deglitch #(.STAGES(SYNC_STAGES)) u_dg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (line_i),
        .lvl_o  (lvl_w)
    );

    blm_pulse_meter #(.CW(CW), .WIN_LEN(WIN_LEN)) u_meter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (c_q.st == ST_MEAS),
        .lvl_i  (lvl_w),
        .done_o (done_w),
        .got_o  (got_w),
        .min_o  (mn_w),
        .max_o  (mx_w)
    );

    blm_bit_watch #(.LOSS_RUN(LOSS_RUN), .PERR_MAX(PERR_MAX)) u_watch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .arm_loss_i  (c_q.st == ST_LOCK),
        .arm_perr_i  ((c_q.st == ST_SYNC) || (c_q.st == ST_LOCK)),
        .bit_vld_i   (dec_bit_vld_i),
        .bit_i       (dec_bit_i),
        .pre_found_i (pre_found_i),
        .pre_err_i   (pre_err_i),
        .loss_o      (loss_w),
        .perr_o      (perr_w)
    );

    // ratio window in integers: reject 2L <= 5S and L > 4S
    always_comb begin
        ext_mn    = {3'b000, mn_w};
        ext_mx    = {3'b000, mx_w};
        two_mx    = ext_mx << 1;
        four_mn   = ext_mn << 2;
        five_mn   = four_mn + ext_mn;
        ratio_bad = (two_mx <= five_mn) || (ext_mx > four_mn);
        too_fine  = (mn_w < RES_MIN);
    end

    always_comb begin
        c_d = c_q;
        if (!enable_i) begin
            c_d = '0;
        end else begin
            unique case (c_q.st)
                ST_IDLE: begin
                    c_d.st = ST_MEAS;
                    c_d.cz = CZ_NONE;
                end
                ST_MEAS: begin
                    if (done_w) begin
                        if (!got_w)         c_d.cz = CZ_NOSIG;
                        else if (too_fine)  c_d.cz = CZ_LOWF;
                        else if (ratio_bad) c_d.cz = CZ_BADF;
                        else begin
                            c_d.cz   = CZ_NONE;
                            c_d.unit = mn_w;
                            c_d.st   = ST_SYNC;
                            c_d.tmo  = '0;
                        end
                    end
                end
                ST_SYNC: begin
                    if (perr_w) begin
                        c_d.rc = 1'b1;
                        c_d.st = ST_MEAS;
                        c_d.cz = CZ_NONE;
                    end else if (pre_found_i && !pre_err_i) begin
                        c_d.st = ST_LOCK;
                        c_d.lk = 1'b1;
                        c_d.cz = CZ_NONE;
                    end else if (c_q.tmo == TMO_LAST) begin
                        c_d.st = ST_MEAS;
                    end else begin
                        c_d.tmo = c_q.tmo + 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (perr_w) begin
                        c_d.rc = 1'b1;
                        c_d.st = ST_MEAS;
                        c_d.cz = CZ_NONE;
                    end else if (loss_w) begin
                        c_d.ls = 1'b1;
                        c_d.st = ST_MEAS;
                        c_d.cz = CZ_NOSIG;
                    end
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign unlocked_o      = (c_q.st == ST_MEAS) || (c_q.st == ST_SYNC);
    assign no_signal_o     = unlocked_o && (c_q.cz == CZ_NOSIG);
    assign bad_format_o    = unlocked_o && (c_q.cz == CZ_BADF);
    assign low_freq_o      = unlocked_o && (c_q.cz == CZ_LOWF);
    assign lock_flag_o     = c_q.lk;
    assign loss_flag_o     = c_q.ls;
    assign rate_chg_flag_o = c_q.rc;
    assign irq_o           = c_q.lk && lock_irq_en_i;
    assign unit_width_o    = c_q.unit;

    assert_unlock_on_enable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(enable_i) |=> unlocked_o);
    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!unlocked_o && !lock_flag_o && !loss_flag_o && !rate_chg_flag_o));
    assert_lock_on_preamble_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && (c_q.st == ST_SYNC) && pre_found_i && !pre_err_i) |=> (!unlocked_o && lock_flag_o));
    assert_sync_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.st == ST_SYNC) |-> (c_q.tmo <= TMO_LAST));
    assert_loss_unlocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(loss_flag_o) |-> (unlocked_o && no_signal_o));
    assert_rate_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rate_chg_flag_o) |-> (unlocked_o && !no_signal_o));
endmodule

// File: tb/biphase_lock_monitor_tb_top.sv
`timescale 1ns/1ps
module biphase_lock_monitor_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, enable = 1'b0, line = 1'b0;
    logic       bit_vld = 1'b0, bit_v = 1'b0, pre_found = 1'b0, pre_err = 1'b0, irq_en = 1'b0;
    logic       unlocked, no_sig, bad_fmt, low_f, lock_f, loss_f, rate_f, irq;
    logic [7:0] unit_w;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int gen_s = 0;
    int gen_l = 0;

    biphase_lock_monitor dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .enable_i        (enable),
        .line_i          (line),
        .dec_bit_vld_i   (bit_vld),
        .dec_bit_i       (bit_v),
        .pre_found_i     (pre_found),
        .pre_err_i       (pre_err),
        .lock_irq_en_i   (irq_en),
        .unlocked_o      (unlocked),
        .no_signal_o     (no_sig),
        .bad_format_o    (bad_fmt),
        .low_freq_o      (low_f),
        .lock_flag_o     (lock_f),
        .loss_flag_o     (loss_f),
        .rate_chg_flag_o (rate_f),
        .irq_o           (irq),
        .unit_width_o    (unit_w)
    );

    // vector: short width, long width, expected class (0 usable,1 none,2 bad,3 slow clock)
    localparam int NV = 11;
    localparam logic [17:0] VECS [NV] = '{
        {8'd4, 8'd12, 2'd0}, {8'd4, 8'd10, 2'd2}, {8'd4, 8'd11, 2'd0},
        {8'd4, 8'd16, 2'd0}, {8'd4, 8'd17, 2'd2}, {8'd3, 8'd12, 2'd0},
        {8'd3, 8'd13, 2'd2}, {8'd2, 8'd6,  2'd3}, {8'd2, 8'd5,  2'd3},
        {8'd1, 8'd1,  2'd1}, {8'd0, 8'd0,  2'd1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic start(input int s, input int l);
        enable = 1'b0;
        cyc(4);
        gen_s = s;
        gen_l = l;
        cyc(8);
        enable = 1'b1;
    endtask

    task automatic preamble();
        pre_found = 1'b1;
        cyc(1);
        pre_found = 1'b0;
    endtask

    task automatic bits(input int n, input logic v);
        bit_vld = 1'b1;
        bit_v   = v;
        cyc(n);
        bit_vld = 1'b0;
    endtask

    task automatic errs(input int n);
        repeat (n) begin
            pre_err = 1'b1;
            cyc(1);
            pre_err = 1'b0;
            cyc(1);
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // line generator: three short levels then one long level, repeated
    initial begin
        forever begin
            if (gen_s == 0) begin
                @(posedge clk);
                #1 line = 1'b0;
            end else begin
                for (int k = 0; k < 4; k++) begin
                    repeat ((k == 3) ? gen_l : gen_s) @(posedge clk);
                    #1 line = ~line;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        settle();
        chk("R1 reset unlocked", int'(unlocked), 0);
        chk("R1 reset lock flag", int'(lock_f), 0);
        chk("R1 reset causes", int'({no_sig, bad_fmt, low_f}), 0);
        chk("R1 reset irq", int'(irq), 0);
        enable = 1'b1;
        cyc(1);
        settle();
        chk("R1 unlocked after enable", int'(unlocked), 1);

        for (int i = 0; i < NV; i++) begin
            int s = int'(VECS[i][17:10]);
            int l = int'(VECS[i][9:2]);
            int e = int'(VECS[i][1:0]);
            start(s, l);
            cyc(1200);
            settle();
            chk($sformatf("R1 row %0d unlocked", i), int'(unlocked), 1);
            if (s == 1)
                chk($sformatf("R2 row %0d glitch line no_signal", i), int'(no_sig), 1);
            else
                chk($sformatf("R3 row %0d no_signal", i), int'(no_sig), int'(e == 1));
            chk($sformatf("R4 row %0d bad_format", i), int'(bad_fmt), int'(e == 2));
            chk($sformatf("R5 row %0d low_freq", i), int'(low_f), int'(e == 3));
            if (e == 0)
                chk($sformatf("R6 row %0d unit width", i), int'(unit_w), s);
        end

        // lock, interrupt gating, loss of signal
        irq_en = 1'b0;
        start(4, 12);
        cyc(1100);
        preamble();
        settle();
        chk("R7 unlocked cleared on preamble", int'(unlocked), 0);
        chk("R7 lock flag set", int'(lock_f), 1);
        chk("R7 irq masked", int'(irq), 0);
        irq_en = 1'b1;
        #1;
        chk("R7 irq enabled", int'(irq), 1);
        bits(31, 1'b1);
        bits(31, 1'b0);
        settle();
        chk("R9 31-bit runs keep lock", int'(unlocked), 0);
        chk("R9 no loss on 31-bit runs", int'(loss_f), 0);
        bits(1, 1'b0);
        settle();
        chk("R9 loss flag on 32nd bit", int'(loss_f), 1);
        chk("R9 unlocked after loss", int'(unlocked), 1);
        chk("R3 no_signal after loss", int'(no_sig), 1);
        chk("R7 lock flag sticky", int'(lock_f), 1);

        // relock, then preamble error runs
        cyc(1100);
        preamble();
        settle();
        chk("R7 relocked", int'(unlocked), 0);
        errs(15);
        settle();
        chk("R10 15 errors keep lock", int'(unlocked), 0);
        preamble();
        errs(15);
        settle();
        chk("R10 good preamble resets error run", int'(unlocked), 0);
        chk("R10 no rate flag yet", int'(rate_f), 0);
        gen_s = 5;
        gen_l = 15;
        errs(1);
        settle();
        chk("R10 rate flag on 16th error", int'(rate_f), 1);
        chk("R10 unlocked after restart", int'(unlocked), 1);
        chk("R10 no_signal clear after restart", int'(no_sig), 0);
        cyc(1100);
        settle();
        chk("R11 unit width remeasured", int'(unit_w), 5);
        chk("R11 still waiting", int'(unlocked), 1);

        // timeout: preamble after the wait window is ignored
        cyc(720);
        preamble();
        settle();
        chk("R8 late preamble ignored", int'(unlocked), 1);

        enable = 1'b0;
        cyc(1);
        settle();
        chk("R1 disable clears unlocked", int'(unlocked), 0);
        chk("R1 disable clears flags", int'({lock_f, loss_f, rate_f}), 0);
        chk("R1 disable clears irq", int'(irq), 0);
        summary();
    end
endmodule